// File: doc/BRIEF.md
# Precision Time-of-Day Counter with Alarm

This block keeps a running time value for precision time protocols. The value has two parts. The first is a 32-bit count of whole seconds. The second is a 31-bit binary fraction of a second, in which 2^31 units make one second. The rate is trimmed by a fractional scheme. Each enabled clock adds a programmable addend to a 32-bit accumulator. Each time that accumulator carries out, the fraction gains a programmable step.

The surrounding logic can change the time in two ways, selected by a mode bit. It can load an absolute time, or it can apply a signed offset, where the top bit of the fractional operand marks a subtraction. An alarm compares the running time against a programmed target and raises a sticky flag. A snapshot strobe captures the seconds value, so that a later read of the seconds matches the fraction that was read alongside the strobe.

Top module: `tod_counter`

## Requirements
- R1: While reset is held, and directly after reset is released, the seconds output, the fraction output, the snapshot output and the alarm flag are all zero, and the accumulator is zero.
- R2: While `run_en` is high, the accumulator gains `addend` on every clock. On each clock where that addition carries out of bit 31, the fraction gains `incr`.
- R3: When the fraction plus `incr` reaches or passes 2^31, the fraction keeps the sum minus 2^31 and the seconds count rises by one.
- R4: While `run_en` is low and no update is requested, the time and the accumulator hold their values.
- R5: A clock with `upd_go` high and `upd_mode` = 0 loads `upd_sec` into the seconds and `upd_sub[30:0]` into the fraction. Bit 31 of `upd_sub` is ignored in this mode.
- R6: A clock with `upd_go` high, `upd_mode` = 1 and `upd_sub[31]` = 0 adds the offset. The fraction becomes the sum modulo 2^31, and the seconds gain `upd_sec` plus one more when the fractional sum is 2^31 or greater.
- R7: A clock with `upd_go` high, `upd_mode` = 1 and `upd_sub[31]` = 1 subtracts the offset. When the fraction is smaller than `upd_sub[30:0]`, it borrows 2^31 and takes one extra second away.
- R8: An update is applied whatever the level of `run_en`. On the clock where it is applied, it replaces any advance from counting.
- R9: After `alm_arm`, the flag rises one clock after the first clock on which {seconds, fraction} is greater than or equal to {`alm_sec`, `alm_sub`}. This includes the case where an update jumps past the target.
- R10: The alarm flag stays high until `alm_clr`. Each arming raises the flag at most once, even while the time stays past the target.
- R11: A clock with `snap` high copies the current seconds into `snap_sec`, which then holds while the seconds go on changing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Counting enable |
| addend | input | 32 | Value added to the accumulator each enabled clock |
| incr | input | 31 | Fraction step applied on each accumulator carry |
| upd_go | input | 1 | Apply an update on this clock |
| upd_mode | input | 1 | 0 = absolute load, 1 = signed offset |
| upd_sec | input | 32 | Seconds operand of the update |
| upd_sub | input | 32 | Fraction operand; bit 31 = subtract in offset mode |
| alm_arm | input | 1 | Arm the alarm |
| alm_clr | input | 1 | Clear the alarm flag |
| alm_sec | input | 32 | Alarm target seconds |
| alm_sub | input | 31 | Alarm target fraction |
| snap | input | 1 | Capture the seconds into the snapshot |
| cur_sec | output | 32 | Current seconds |
| cur_sub | output | 31 | Current fraction |
| snap_sec | output | 32 | Captured seconds |
| alm_flag | output | 1 | Sticky alarm flag |

## Verification
Updates, counting steps and snapshots show at the outputs one rising edge after the clock on which they were requested. The alarm flag needs a second edge: one edge moves the time, and the next edge raises the flag. The bench drives every input on the falling edge and reads the outputs on a later falling edge. The number of rising edges between driving and reading is the latency of the result being checked. The expected time after an offset comes from a flat 63-bit sum in the bench, not from separate seconds and fraction arithmetic.

// File: rtl/tod_counter.sv
module tod_counter #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 31,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [ACC_W-1:0] addend,
  input  logic [SUB_W-1:0] incr,
  input  logic             upd_go,
  input  logic             upd_mode,
  input  logic [SEC_W-1:0] upd_sec,
  input  logic [SUB_W:0]   upd_sub,
  input  logic             alm_arm,
  input  logic             alm_clr,
  input  logic [SEC_W-1:0] alm_sec,
  input  logic [SUB_W-1:0] alm_sub,
  input  logic             snap,
  output logic [SEC_W-1:0] cur_sec,
  output logic [SUB_W-1:0] cur_sub,
  output logic [SEC_W-1:0] snap_sec,
  output logic             alm_flag
);

  logic [ACC_W-1:0] acc;
  logic             armed;

  logic [ACC_W:0] acc_sum;
  logic           tick;
  assign acc_sum = {1'b0, acc} + {1'b0, addend};
  assign tick    = run_en & acc_sum[ACC_W];

  logic [SUB_W:0] step_sum;
  assign step_sum = {1'b0, cur_sub} + (tick ? {1'b0, incr} : '0);

  logic [SUB_W-1:0] off;
  logic             neg;
  assign off = upd_sub[SUB_W-1:0];
  assign neg = upd_sub[SUB_W];

  logic [SUB_W:0] add_sum, dif;
  assign add_sum = {1'b0, cur_sub} + {1'b0, off};
  assign dif     = {1'b0, cur_sub} - {1'b0, off};

  logic [SEC_W-1:0] add_sec, sub_sec;
  assign add_sec = cur_sec + upd_sec + SEC_W'(add_sum[SUB_W]);
  assign sub_sec = cur_sec - upd_sec - SEC_W'(dif[SUB_W]);

  logic [SEC_W-1:0] nxt_sec;
  logic [SUB_W-1:0] nxt_sub;
  always_comb begin
    nxt_sec = cur_sec + SEC_W'(step_sum[SUB_W]);
    nxt_sub = step_sum[SUB_W-1:0];
    if (upd_go) begin
      if (!upd_mode) begin
        nxt_sec = upd_sec;
        nxt_sub = off;
      end else if (neg) begin
        nxt_sec = sub_sec;
        nxt_sub = dif[SUB_W-1:0];
      end else begin
        nxt_sec = add_sec;
        nxt_sub = add_sum[SUB_W-1:0];
      end
    end
  end

  logic reached, fire;
  assign reached = {cur_sec, cur_sub} >= {alm_sec, alm_sub};
  assign fire    = armed & reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      cur_sec  <= '0;
      cur_sub  <= '0;
      snap_sec <= '0;
      armed    <= 1'b0;
      alm_flag <= 1'b0;
    end else begin
      if (run_en) acc <= acc_sum[ACC_W-1:0];
      cur_sec  <= nxt_sec;
      cur_sub  <= nxt_sub;
      if (snap) snap_sec <= cur_sec;
      armed    <= alm_arm | (armed & ~reached);
      alm_flag <= fire | (alm_flag & ~alm_clr);
    end
  end

endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             upd_go,
  input logic             upd_mode,
  input logic [SEC_W-1:0] upd_sec,
  input logic [SUB_W:0]   upd_sub,
  input logic             alm_clr,
  input logic [SEC_W-1:0] alm_sec,
  input logic [SUB_W-1:0] alm_sub,
  input logic             snap,
  input logic [SEC_W-1:0] cur_sec,
  input logic [SUB_W-1:0] cur_sub,
  input logic [SEC_W-1:0] snap_sec,
  input logic             alm_flag
);

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !upd_go) |=> ($stable(cur_sec) && $stable(cur_sub))); // R4

  AST_ABS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_go && !upd_mode) |=> (cur_sec == $past(upd_sec) && cur_sub == $past(upd_sub[SUB_W-1:0]))); // R5

  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_flag) |-> $past({cur_sec, cur_sub} >= {alm_sec, alm_sub})); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_flag && !alm_clr) |=> alm_flag); // R10

  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (snap_sec == $past(cur_sec))); // R11

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(snap_sec)); // R11

endmodule

bind tod_counter tod_counter_chk #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .upd_go(upd_go), .upd_mode(upd_mode),
  .upd_sec(upd_sec), .upd_sub(upd_sub), .alm_clr(alm_clr), .alm_sec(alm_sec),
  .alm_sub(alm_sub), .snap(snap), .cur_sec(cur_sec), .cur_sub(cur_sub),
  .snap_sec(snap_sec), .alm_flag(alm_flag)
);

// File: tb/tod_counter_test.sv
module tod_counter_test;
  localparam int CLK_P = 10;
  localparam int NV = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic [31:0] addend = '0;
  logic [30:0] incr = '0;
  logic        upd_go = 1'b0, upd_mode = 1'b0;
  logic [31:0] upd_sec = '0, upd_sub = '0;
  logic        alm_arm = 1'b0, alm_clr = 1'b0;
  logic [31:0] alm_sec = 32'hFFFF_FFFF;
  logic [30:0] alm_sub = '1;
  logic        snap = 1'b0;
  logic [31:0] cur_sec, snap_sec;
  logic [30:0] cur_sub;
  logic        alm_flag;

  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  tod_counter uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .addend(addend), .incr(incr),
    .upd_go(upd_go), .upd_mode(upd_mode), .upd_sec(upd_sec), .upd_sub(upd_sub),
    .alm_arm(alm_arm), .alm_clr(alm_clr), .alm_sec(alm_sec), .alm_sub(alm_sub),
    .snap(snap), .cur_sec(cur_sec), .cur_sub(cur_sub), .snap_sec(snap_sec),
    .alm_flag(alm_flag)
  );

  // vector table: mode, start sec, start sub, update sec, update sub (bit 31 = subtract)
  localparam logic        V_MODE [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic [31:0] V_S0   [NV] = '{32'd3, 32'd10, 32'd10, 32'd10, 32'd10, 32'd5, 32'd1};
  localparam logic [31:0] V_F0   [NV] = '{32'd9, 32'd1000, 32'h7FFF_FF00, 32'd1000, 32'd100, 32'd300, 32'h7FFF_FFFF};
  localparam logic [31:0] V_US   [NV] = '{32'h1234, 32'd3, 32'd1, 32'd3, 32'd2, 32'd5, 32'd0};
  localparam logic [31:0] V_UF   [NV] = '{32'h8000_0123, 32'd500, 32'd512, 32'h8000_0190,
                                          32'h8000_012C, 32'h8000_012C, 32'd1};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic upd(input logic m, input logic [31:0] s, input logic [31:0] f);
    upd_mode = m; upd_sec = s; upd_sub = f; upd_go = 1'b1;
    @(negedge clk);
    upd_go = 1'b0;
  endtask

  task automatic run(input int n);
    run_en = 1'b1;
    repeat (n) @(negedge clk);
    run_en = 1'b0;
  endtask

  function automatic logic [63:0] flat(input logic [31:0] s, input logic [30:0] f);
    return {1'b0, s, f};
  endfunction

  initial begin
    repeat (1000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sec in reset", cur_sec, 0);
    rst_n = 1'b1;
    chk("R1 sub after reset", cur_sub, 0);
    chk("R1 flag after reset", alm_flag, 0);
    chk("R1 snap after reset", snap_sec, 0);

    // R2: addend 2^31 gives a carry every second clock
    addend = 32'h8000_0000; incr = 31'd100;
    run(20);
    chk("R2 half-rate count", flat(cur_sec, cur_sub), flat(0, 1000));
    // R4: no advance while disabled
    repeat (10) @(negedge clk);
    chk("R4 frozen", flat(cur_sec, cur_sub), flat(0, 1000));
    // R2: addend 2^30 carries every fourth clock
    addend = 32'h4000_0000;
    run(8);
    chk("R2 quarter-rate count", flat(cur_sec, cur_sub), flat(0, 1200));
    // R3: rollover into seconds
    addend = 32'h8000_0000;
    upd(1'b0, 32'd5, 32'h7FFF_FFCE);
    run(2);
    chk("R3 rollover", flat(cur_sec, cur_sub), flat(6, 50));

    // vector table: R5 load, R6 add, R7 subtract, R8 applied with run_en low
    for (int i = 0; i < NV; i++) begin
      logic [63:0] t, o, e;
      upd(1'b0, V_S0[i], V_F0[i]);
      upd(V_MODE[i], V_US[i], V_UF[i]);
      t = flat(V_S0[i], V_F0[i][30:0]);
      o = flat(V_US[i], V_UF[i][30:0]);
      if (!V_MODE[i]) e = o;
      else if (V_UF[i][31]) e = (t - o) & 64'h7FFF_FFFF_FFFF_FFFF;
      else e = (t + o) & 64'h7FFF_FFFF_FFFF_FFFF;
      chk(!V_MODE[i] ? "R5 R8 absolute load" : (V_UF[i][31] ? "R7 R8 offset subtract" : "R6 R8 offset add"),
          flat(cur_sec, cur_sub), e);
    end

    // R9 R10 alarm reached by counting, with equality at the boundary
    upd(1'b0, 32'd50, 32'd1000);
    alm_sec = 32'd50; alm_sub = 31'd1300;
    alm_arm = 1'b1; @(negedge clk); alm_arm = 1'b0;
    run(4);
    repeat (2) @(negedge clk);
    chk("R9 flag low before target", alm_flag, 0);
    run(2);
    @(negedge clk);
    chk("R9 flag at equal time", alm_flag, 1);
    repeat (5) @(negedge clk);
    chk("R10 flag sticky", alm_flag, 1);
    alm_clr = 1'b1; @(negedge clk); alm_clr = 1'b0;
    chk("R10 flag cleared", alm_flag, 0);
    repeat (5) @(negedge clk);
    chk("R10 once per arming", alm_flag, 0);

    // R9 update jumps past target
    alm_sec = 32'd100; alm_sub = 31'd0;
    alm_arm = 1'b1; @(negedge clk); alm_arm = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 not yet past", alm_flag, 0);
    upd(1'b0, 32'd200, 32'd0);
    @(negedge clk);
    chk("R9 jump past target", alm_flag, 1);
    alm_clr = 1'b1; @(negedge clk); alm_clr = 1'b0;

    // R8 update wins over a counting tick on the same clock
    addend = 32'hFFFF_FFFF; incr = 31'd5;
    run(3);
    run_en = 1'b1;
    upd(1'b0, 32'd20, 32'd0);
    run_en = 1'b0;
    chk("R8 update over tick", flat(cur_sec, cur_sub), flat(20, 0));

    // R11 snapshot holds seconds
    upd(1'b0, 32'd7, 32'd0);
    snap = 1'b1; @(negedge clk); snap = 1'b0;
    upd(1'b0, 32'd9, 32'd0);
    chk("R11 snapshot held", snap_sec, 7);
    chk("R11 live seconds moved", cur_sec, 9);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule